// File: doc/BRIEF.md
# Two-Pass Conversion Sequencer

This block is the digital control core of a two-pass subranging analog-to-digital converter. A rising edge on an asynchronous convert-start input launches one conversion. The sequencer then holds the input sampler, waits out a coarse first pass and presents the coarse 9-bit code to the reconstruction DAC with its low bits cleared. It lets the DAC and residue path settle, and then runs a second 9-bit pass on the amplified residue. During that second pass the input sampler already tracks the next sample.

When both passes are complete, the two 9-bit codes are merged into one 16-bit two's complement word and written to an output latch. A status line stays low for the whole conversion. It goes high a fixed number of internal clock cycles after the latch has been written. The latch is read through an active-low select/read port, either as one 16-bit word or, in the byte variant, as an upper or lower byte chosen by a select input. The analog comparators are modelled by two 9-bit code inputs that the sequencer samples at the end of each pass. Every phase length is a parameter counted in internal clock cycles.

Top module: `adc_seq_top`

## Requirements
- R1: A low-to-high transition on `conv_start_i` is resynchronised. `busy_o` goes low, and `input_hold_o` goes high, after the third rising clock edge that follows the transition.
- R2: `busy_o` stays low for exactly T_PASS1 + T_SETTLE + T_PASS2 + 1 + T_TAIL clock cycles and then returns high.
- R3: After the first pass, `dac_word_o` equals the sampled coarse code in bits 15:7, with bits 6:0 at zero. It keeps this value through the settling window and the second pass.
- R4: `res_sw_settle_o` is high during the first pass and the settling window. `res_sw_pass2_o` and `res_hold_o` are high only during the second pass. The two switch outputs are never high together.
- R5: `input_hold_o` is high from the start of conversion to the end of the settling window. It is low (track) throughout the second pass.
- R6: The output latch is written T_TAIL cycles before `busy_o` rises. It does not change on the cycle in which `busy_o` rises.
- R7: Result = saturate(coarse*128 + fine - 256) to the range 0..65535, with bit 15 then inverted. Coarse 256 with fine 256 gives 0x0000. Coarse 0 with fine 0 gives 0x8000. Coarse 511 with fine 511 gives 0x7FFF.
- R8: `data_oe_o` is high only while `cs_n_i` and `rd_n_i` are both low. While it is high, `data_o` carries the latched result.
- R9: When BYTE_READ is 1, `data_o` is 8 bits wide. `byte_hi_i` = 1 returns result bits 15:8, and `byte_hi_i` = 0 returns bits 7:0.
- R10: A convert-start rising edge that arrives while `busy_o` is low is ignored. It neither lengthens the conversion nor starts a new one.
- R11: After reset, `busy_o` is high, all hold and switch outputs are low, `data_oe_o` is low and the latch reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start_i | input | 1 | Asynchronous convert-start, rising edge active |
| coarse_code_i | input | 9 | First-pass flash code |
| fine_code_i | input | 9 | Second-pass flash code, offset by half range |
| busy_o | output | 1 | Low while a conversion is in progress |
| input_hold_o | output | 1 | Input sampler hold (1) / track (0) |
| res_sw_settle_o | output | 1 | Residue switch closed during pass one and settling |
| res_sw_pass2_o | output | 1 | Residue switch closed during pass two |
| res_hold_o | output | 1 | Residue sampler hold during pass two |
| dac_word_o | output | 16 | Reconstruction DAC word |
| cs_n_i | input | 1 | Active-low chip select |
| rd_n_i | input | 1 | Active-low read strobe |
| byte_hi_i | input | 1 | Byte select in byte variant (1 = upper) |
| data_o | output | DATA_W (16, or 8 when BYTE_READ=1) | Read data |
| data_oe_o | output | 1 | Bus drive enable; low means high impedance |

## Verification
`busy_o` falls three clock edges after the start edge, because of the two-stage synchroniser and the edge register. Every phase output is then due a fixed number of cycles after that fall: the DAC word and the settle switch after T_PASS1, and the pass-two controls after a further T_SETTLE. The bench finds the falling edge by polling on falling clock edges. It then counts falling edges from that point and samples each control exactly at the index where the phase has changed. The read port is combinational, so the bench samples it a short delay after driving select and read within one clock low phase. The coarse code is swept over all 512 values, with a varying fine code and explicit saturation corners, and each result is compared with the arithmetic formula.

// File: rtl/adc_seq_pkg.sv
// Shared definitions for the two-pass conversion sequencer.
package adc_seq_pkg;
    // Phases of one conversion, in the order they are visited.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_PASS1  = 3'd1,
        PH_SETTLE = 3'd2,
        PH_PASS2  = 3'd3,
        PH_LATCH  = 3'd4,
        PH_TAIL   = 3'd5
    } phase_t;
endpackage

// File: rtl/adc_seq_sync.sv
// Resynchronises the asynchronous convert-start input and emits a
// one-cycle pulse on its rising edge.
// Assumes: the input is held for at least two clock periods.
module adc_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] meta_q;
    logic              last_q;

    // Shift the async level through the synchroniser chain, keep previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            last_q <= 1'b0;
        end else begin
            meta_q <= {meta_q[STAGES-2:0], async_i};
            last_q <= meta_q[STAGES-1];
        end
    end

    assign rise_o = meta_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
// Phase controller: steps pass one, settling, pass two, latch and tail,
// samples the two flash codes at the end of their passes, and decodes
// the hold and switch controls from the current phase.
// Assumes: all phase lengths are at least 1 cycle.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CODE_W   = 9,
    parameter int T_PASS1  = 168,
    parameter int T_SETTLE = 48,
    parameter int T_PASS2  = 40,
    parameter int T_TAIL   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] coarse_i,
    input  logic [CODE_W-1:0] fine_i,
    output phase_t            phase_o,
    output logic [CODE_W-1:0] coarse_q_o,
    output logic [CODE_W-1:0] fine_q_o,
    output logic              latch_en_o
);
    localparam int MAX12 = (T_PASS1 > T_SETTLE) ? T_PASS1 : T_SETTLE;
    localparam int MAX34 = (T_PASS2 > T_TAIL) ? T_PASS2 : T_TAIL;
    localparam int MAXT  = (MAX12 > MAX34) ? MAX12 : MAX34;
    localparam int CNT_W = (MAXT > 1) ? $clog2(MAXT) : 1;
    localparam logic [CNT_W-1:0] END1 = CNT_W'(T_PASS1 - 1);
    localparam logic [CNT_W-1:0] ENDS = CNT_W'(T_SETTLE - 1);
    localparam logic [CNT_W-1:0] END2 = CNT_W'(T_PASS2 - 1);
    localparam logic [CNT_W-1:0] ENDT = CNT_W'(T_TAIL - 1);

    phase_t           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q;

    // Choose the next phase from the current phase and its cycle count.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (start_i)       phase_d = PH_PASS1;
            PH_PASS1:  if (cnt_q == END1) phase_d = PH_SETTLE;
            PH_SETTLE: if (cnt_q == ENDS) phase_d = PH_PASS2;
            PH_PASS2:  if (cnt_q == END2) phase_d = PH_LATCH;
            PH_LATCH:                     phase_d = PH_TAIL;
            PH_TAIL:   if (cnt_q == ENDT) phase_d = PH_IDLE;
            default:                      phase_d = PH_IDLE;
        endcase
    end

    // Register the phase and restart the cycle counter on each change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= (phase_d != phase_q) ? '0 : cnt_q + 1'b1;
        end
    end

    // Capture each flash code on the last cycle of its pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q_o <= '0;
            fine_q_o   <= '0;
        end else begin
            if (phase_q == PH_PASS1 && phase_d == PH_SETTLE) coarse_q_o <= coarse_i;
            if (phase_q == PH_PASS2 && phase_d == PH_LATCH)  fine_q_o   <= fine_i;
        end
    end

    assign phase_o    = phase_q;
    assign latch_en_o = (phase_q == PH_LATCH);
endmodule

// File: rtl/adc_seq_correct.sv
// Merges coarse and fine codes into the output word and holds it.
// The fine code carries an offset of half its range; the sum is clamped
// to the offset-binary range and the top bit inverted for two's complement.
// Assumes: RES_W > CODE_W.
module adc_seq_correct #(
    parameter int CODE_W = 9,
    parameter int RES_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] coarse_i,
    input  logic [CODE_W-1:0] fine_i,
    output logic [RES_W-1:0]  result_o
);
    localparam int SHIFT = RES_W - CODE_W;
    localparam int SUM_W = RES_W + 2;
    localparam logic signed [SUM_W-1:0] FINE_OFS = SUM_W'(1 << (CODE_W - 1));
    localparam logic signed [SUM_W-1:0] TOP      = SUM_W'((1 << RES_W) - 1);

    logic signed [SUM_W-1:0] sum;
    logic [RES_W-1:0]        clamped;

    // Offset-corrected sum of both passes with clamping.
    always_comb begin
        sum = (SUM_W'(coarse_i) <<< SHIFT) + SUM_W'(fine_i) - FINE_OFS;
        if (sum < 0)        clamped = '0;
        else if (sum > TOP) clamped = '1;
        else                clamped = sum[RES_W-1:0];
    end

    // Output latch, written once per conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)      result_o <= '0;
        else if (load_i) result_o <= {~clamped[RES_W-1], clamped[RES_W-2:0]};
    end
endmodule

// File: rtl/adc_seq_rdport.sv
// Read port: drives the latched result while select and read are low,
// as one word or as a selectable byte.
// Assumes: RES_W is twice 8 when BYTE_READ is set.
module adc_seq_rdport #(
    parameter int RES_W     = 16,
    parameter bit BYTE_READ = 1'b0,
    localparam int DATA_W   = BYTE_READ ? RES_W / 2 : RES_W
) (
    input  logic [RES_W-1:0]  result_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              byte_hi_i,
    output logic [DATA_W-1:0] data_o,
    output logic              oe_o
);
    assign oe_o = ~cs_n_i & ~rd_n_i;

    generate
        if (BYTE_READ) begin : g_byte
            // Pick the requested half of the result.
            always_comb data_o = byte_hi_i ? result_i[RES_W-1:DATA_W] : result_i[DATA_W-1:0];
        end else begin : g_word
            logic unused_sel;
            assign unused_sel = byte_hi_i;
            // Whole word straight through.
            always_comb data_o = result_i;
        end
    endgenerate
endmodule

// File: rtl/adc_seq_top.sv
// Two-pass conversion sequencer top: start synchroniser, phase controller,
// correction latch and read port.
// Assumes: flash codes are stable at the end of their pass.
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int CODE_W    = 9,
    parameter int RES_W     = 16,
    parameter int T_PASS1   = 168,
    parameter int T_SETTLE  = 48,
    parameter int T_PASS2   = 40,
    parameter int T_TAIL    = 2,
    parameter bit BYTE_READ = 1'b0,
    localparam int DATA_W   = BYTE_READ ? RES_W / 2 : RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start_i,
    input  logic [CODE_W-1:0] coarse_code_i,
    input  logic [CODE_W-1:0] fine_code_i,
    output logic              busy_o,
    output logic              input_hold_o,
    output logic              res_sw_settle_o,
    output logic              res_sw_pass2_o,
    output logic              res_hold_o,
    output logic [RES_W-1:0]  dac_word_o,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              byte_hi_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o
);
    localparam int SHIFT = RES_W - CODE_W;

    logic              start_pulse;
    phase_t            phase;
    logic [CODE_W-1:0] coarse_q, fine_q;
    logic              latch_en;
    logic [RES_W-1:0]  result_q;

    adc_seq_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(conv_start_i), .rise_o(start_pulse)
    );

    adc_seq_ctrl #(
        .CODE_W(CODE_W), .T_PASS1(T_PASS1), .T_SETTLE(T_SETTLE),
        .T_PASS2(T_PASS2), .T_TAIL(T_TAIL)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_pulse),
        .coarse_i(coarse_code_i), .fine_i(fine_code_i),
        .phase_o(phase), .coarse_q_o(coarse_q), .fine_q_o(fine_q),
        .latch_en_o(latch_en)
    );

    adc_seq_correct #(.CODE_W(CODE_W), .RES_W(RES_W)) corr_i (
        .clk(clk), .rst_n(rst_n), .load_i(latch_en),
        .coarse_i(coarse_q), .fine_i(fine_q), .result_o(result_q)
    );

    adc_seq_rdport #(.RES_W(RES_W), .BYTE_READ(BYTE_READ)) rd_i (
        .result_i(result_q), .cs_n_i(cs_n_i), .rd_n_i(rd_n_i),
        .byte_hi_i(byte_hi_i), .data_o(data_o), .oe_o(data_oe_o)
    );

    // Analog control decode from the current phase.
    always_comb begin
        busy_o          = (phase == PH_IDLE);
        input_hold_o    = (phase == PH_PASS1) || (phase == PH_SETTLE);
        res_sw_settle_o = input_hold_o;
        res_sw_pass2_o  = (phase == PH_PASS2);
        res_hold_o      = (phase == PH_PASS2);
    end

    assign dac_word_o = {coarse_q, {SHIFT{1'b0}}};
endmodule

// File: rtl/adc_seq_chk.sv
// Property checker for the conversion sequencer, bound into the top.
// Counts busy-low cycles so that the conversion length can be checked
// without parameter-deep delays.
module adc_seq_chk #(
    parameter int RES_W = 16,
    parameter int TOTAL = 259
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_pulse,
    input logic             busy,
    input logic             input_hold,
    input logic             sw_settle,
    input logic             sw_pass2,
    input logic             res_hold,
    input logic [RES_W-1:0] result
);
    logic [31:0] low_cnt;

    // Length of the current busy-low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n)     low_cnt <= '0;
        else if (!busy) low_cnt <= low_cnt + 1;
        else            low_cnt <= '0;
    end

    a_r1_start_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && busy) |=> (!busy && input_hold));

    a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy) && low_cnt != 0) |-> (low_cnt == TOTAL));

    a_r4_switch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_settle && sw_pass2));

    a_r5_track_in_pass2: assert property (@(posedge clk) disable iff (!rst_n)
        res_hold |-> !input_hold);

    a_r6_result_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy) && low_cnt != 0) |-> $stable(result));
endmodule

bind adc_seq_top adc_seq_chk #(
    .RES_W(RES_W),
    .TOTAL(T_PASS1 + T_SETTLE + T_PASS2 + 1 + T_TAIL)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .busy(busy_o),
    .input_hold(input_hold_o), .sw_settle(res_sw_settle_o),
    .sw_pass2(res_sw_pass2_o), .res_hold(res_hold_o), .result(result_q)
);

// File: tb/adc_seq_top_tb_top.sv
module adc_seq_top_tb_top;
    localparam int T1 = 4, TS = 3, T2 = 4, TL = 2;
    localparam int TOTAL = T1 + TS + T2 + 1 + TL;

    logic clk = 1'b0, rst_n = 1'b0, conv = 1'b0;
    logic [8:0] coarse = '0, fine = '0;
    logic cs_n = 1'b1, rd_n = 1'b1, byte_hi = 1'b0;
    logic busy, hold, sw_s, sw_p, rhold, oe;
    logic [15:0] dac, data_w;
    logic busy_b, hold_b, sw_s_b, sw_p_b, rhold_b, oe_b;
    logic [15:0] dac_b;
    logic [7:0] data_b;
    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    adc_seq_top #(.T_PASS1(T1), .T_SETTLE(TS), .T_PASS2(T2), .T_TAIL(TL), .BYTE_READ(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_start_i(conv), .coarse_code_i(coarse), .fine_code_i(fine),
        .busy_o(busy), .input_hold_o(hold), .res_sw_settle_o(sw_s), .res_sw_pass2_o(sw_p),
        .res_hold_o(rhold), .dac_word_o(dac), .cs_n_i(cs_n), .rd_n_i(rd_n), .byte_hi_i(byte_hi),
        .data_o(data_w), .data_oe_o(oe));

    adc_seq_top #(.T_PASS1(T1), .T_SETTLE(TS), .T_PASS2(T2), .T_TAIL(TL), .BYTE_READ(1'b1)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .conv_start_i(conv), .coarse_code_i(coarse), .fine_code_i(fine),
        .busy_o(busy_b), .input_hold_o(hold_b), .res_sw_settle_o(sw_s_b), .res_sw_pass2_o(sw_p_b),
        .res_hold_o(rhold_b), .dac_word_o(dac_b), .cs_n_i(cs_n), .rd_n_i(rd_n), .byte_hi_i(byte_hi),
        .data_o(data_b), .data_oe_o(oe_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input int c, input int f);
        int s = c * 128 + f - 256;
        if (s < 0) s = 0;
        if (s > 65535) s = 65535;
        return 16'(s) ^ 16'h8000;
    endfunction

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Read the latched result through both ports and compare (R7, R8, R9).
    task automatic read_and_check(input logic [15:0] exp);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; byte_hi = 1'b1; #2;
        chk("R8 oe during read", {30'd0, oe, oe_b}, 32'd3);
        chk("R7 word result", data_w, exp);
        chk("R9 upper byte", data_b, exp[15:8]);
        byte_hi = 1'b0; #2;
        chk("R9 lower byte", data_b, exp[7:0]);
        rd_n = 1'b1; #2;
        chk("R8 oe off with read high", {30'd0, oe, oe_b}, 32'd0);
        cs_n = 1'b1;
    endtask

    task automatic run_conv(input int c, input int f, input bit poke);
        int k, idx;
        @(negedge clk); coarse = 9'(c); fine = 9'(f); conv = 1'b1;
        k = 0;
        do begin @(negedge clk); k++; end while (busy && k < 10);
        chk("R1 busy fall latency", k, 3);
        chk("R1 hold at start", hold, 1'b1);
        idx = 0;
        while (!busy && idx < 100) begin
            if (poke && idx == 2) conv = 1'b0;
            if (poke && idx == 4) conv = 1'b1;
            if (idx == T1) begin
                chk("R3 dac word", dac, {9'(c), 7'd0});
                chk("R4 settle switch", {30'd0, sw_s, sw_p}, 32'd2);
                chk("R5 hold in settle", hold, 1'b1);
            end
            if (idx == T1 + TS) begin
                chk("R4 pass2 controls", {29'd0, sw_s, sw_p, rhold}, 32'd3);
                chk("R5 track in pass2", hold, 1'b0);
                chk("R3 dac kept", dac, {9'(c), 7'd0});
            end
            @(negedge clk); idx++;
        end
        chk(poke ? "R10 length with extra edge" : "R2 busy length", idx, TOTAL);
        conv = 1'b0;
        if (poke) begin
            repeat (8) @(negedge clk);
            chk("R10 no restart", busy, 1'b1);
        end
        read_and_check(model(c, f));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", {31'd0, busy}, 32'd1);
        chk("R11 controls", {28'd0, hold, sw_s, sw_p, rhold}, 32'd0);
        chk("R11 oe", oe, 1'b0);
        cs_n = 1'b0; #2;
        chk("R8 cs only no drive", oe, 1'b0);
        cs_n = 1'b1;
        read_and_check(16'h0000);
        // Corners of the correction (R7)
        run_conv(256, 256, 0);
        run_conv(0, 0, 0);
        run_conv(0, 255, 0);
        run_conv(0, 257, 0);
        run_conv(511, 511, 0);
        run_conv(511, 383, 0);
        run_conv(511, 384, 0);
        run_conv(255, 511, 0);
        run_conv(300, 100, 1);
        // Sweep of every coarse code with a varying fine code
        for (int c = 0; c < 512; c++) run_conv(c, (c * 149 + 13) % 512, (c % 64) == 7);
        done = 1;
        finish_run();
    end
endmodule